// File: doc/BRIEF.md
# Per-Bank Strobe Hold-Low Reset Detector

This block sits beside the control logic of a memory device that is split into independently selected banks. No separate reset pin exists. A bank is reset when its active-low bank select, together with the shared active-low write strobe and output strobe, is held low for longer than a configured number of clock cycles. All strobes are asynchronous to the system clock, so each passes through a two-stage synchronizer before any counting happens.

While a bank is in reset, its reset output tells the bank's control logic to abandon any operation in progress and return to its initial state. A one-cycle strobe on reset entry clears the bank's status register. The reset ends as soon as any of the three strobes returns high. The bank's read-data-valid output then stays low for a further recovery interval. A sticky per-bank flag records that the bank has been through at least one complete reset since power-up. Selecting two banks at the same time is illegal: the block flags it, and such a pattern never counts toward a reset.

All pins are plain control and status levels. No data flows through the block, so it has no valid/ready handshake and nothing can be held off.

Top module: `bank_hold_reset`

## Requirements
- R1: A bank's `bank_rst` bit rises only when its select, `wr_en_n` and `out_en_n` are all seen low, with no other bank selected, for more than `HOLD_CYCLES` consecutive clock cycles after synchronization. Holding for exactly `HOLD_CYCLES` cycles never causes a reset.
- R2: `stat_clr` bit b pulses high for exactly one cycle, in the same cycle that `bank_rst` bit b rises, and at no other time.
- R3: `bank_rst` bit b falls in the first cycle after any of that bank's three strobes is seen high.
- R4: `data_ok` bit b is low while bank b is in reset. It returns high exactly `RECOV_CYCLES`+1 cycles after `bank_rst` bit b falls, unless a new reset starts first. After power-on reset it is high.
- R5: `bank_init` bit b is low after power-on reset. It becomes high when the first reset of bank b ends, and then stays high.
- R6: `dual_sel_err` is high one cycle after the synchronized selects show more than one bank low at once. While more than one bank is selected, no bank counts toward a reset.
- R7: A single cycle in which any strobe is seen high before the threshold restarts the bank's low-time count from zero.
- R8: Banks are reset independently, so at most one `bank_rst` bit is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| bank_en_n | input | NUM_BANKS | Active-low bank selects, asynchronous |
| wr_en_n | input | 1 | Active-low write strobe, asynchronous |
| out_en_n | input | 1 | Active-low output strobe, asynchronous |
| bank_rst | output | NUM_BANKS | Per-bank reset/abort level |
| stat_clr | output | NUM_BANKS | Per-bank one-cycle status-clear strobe |
| bank_init | output | NUM_BANKS | Per-bank sticky initialized flag |
| data_ok | output | NUM_BANKS | Per-bank read-data-valid level |
| dual_sel_err | output | 1 | More than one bank selected at once |

## Verification
The bench holds the strobes low for exactly the threshold and for one cycle more. An off-by-one counter would reset too early or not at all. It inserts one-cycle high glitches late in a hold: a counter that pauses instead of restarting would fire early. It also times the recovery window to the cycle, so a window that is one cycle short or long makes `data_ok` rise at the wrong point. Two banks are selected together to confirm the error flag and that neither bank resets. Seeded random strobe patterns stress re-entry into reset during recovery.

// File: rtl/bank_hold_reset_pkg.sv
package bank_hold_reset_pkg;
  typedef enum logic [1:0] {
    CH_RUN   = 2'd0,
    CH_HELD  = 2'd1,
    CH_RECOV = 2'd2
  } ch_state_e;
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  // Reset to all ones: the strobes are active low, so ones mean idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= async_in;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/bank_channel.sv
module bank_channel
  import bank_hold_reset_pkg::*;
#(
  parameter int HOLD_CYCLES  = 625,
  parameter int RECOV_CYCLES = 94
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_low,
  input  logic exclusive,
  output logic in_rst,
  output logic clr_pulse,
  output logic init_done,
  output logic data_valid
);
  localparam int CW  = $clog2(HOLD_CYCLES + 1);
  localparam int CWS = (CW < 1) ? 1 : CW;
  localparam int RW  = $clog2(RECOV_CYCLES + 1);
  localparam int RWS = (RW < 1) ? 1 : RW;
  localparam logic [CWS-1:0] HOLD_LAST  = CWS'(HOLD_CYCLES);
  localparam logic [RWS-1:0] RECOV_LAST = RWS'(RECOV_CYCLES);

  ch_state_e      st;
  logic [CWS-1:0] low_cnt;
  logic [RWS-1:0] rec_cnt;
  logic           counting;

  assign counting = all_low && exclusive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= CH_RUN;
      low_cnt    <= '0;
      rec_cnt    <= '0;
      in_rst     <= 1'b0;
      clr_pulse  <= 1'b0;
      init_done  <= 1'b0;
      data_valid <= 1'b1;
    end else begin
      clr_pulse <= 1'b0;
      unique case (st)
        CH_RUN, CH_RECOV: begin
          if (counting && low_cnt == HOLD_LAST) begin
            // Threshold passed: enter reset; this overrides any recovery in progress.
            st         <= CH_HELD;
            low_cnt    <= '0;
            in_rst     <= 1'b1;
            clr_pulse  <= 1'b1;
            data_valid <= 1'b0;
          end else begin
            low_cnt <= counting ? low_cnt + 1'b1 : '0;
            if (st == CH_RECOV) begin
              if (rec_cnt == RECOV_LAST) begin
                data_valid <= 1'b1;
                st         <= CH_RUN;
              end else begin
                rec_cnt <= rec_cnt + 1'b1;
              end
            end
          end
        end
        CH_HELD: begin
          if (!all_low) begin
            st        <= CH_RECOV;
            in_rst    <= 1'b0;
            init_done <= 1'b1;
            rec_cnt   <= '0;
          end
        end
        default: st <= CH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/bank_hold_reset.sv
module bank_hold_reset
  import bank_hold_reset_pkg::*;
#(
  parameter int NUM_BANKS    = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_CYCLES  = 625,
  parameter int RECOV_CYCLES = 94
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] bank_en_n,
  input  logic                 wr_en_n,
  input  logic                 out_en_n,
  output logic [NUM_BANKS-1:0] bank_rst,
  output logic [NUM_BANKS-1:0] stat_clr,
  output logic [NUM_BANKS-1:0] bank_init,
  output logic [NUM_BANKS-1:0] data_ok,
  output logic                 dual_sel_err
);
  localparam int SW = NUM_BANKS + 2;
  localparam int SELW = $clog2(NUM_BANKS + 1);

  logic [SW-1:0]        s_all;
  logic [NUM_BANKS-1:0] s_sel;
  logic                 s_we_n, s_oe_n;
  logic [SELW-1:0]      sel_count;

  strobe_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({bank_en_n, wr_en_n, out_en_n}),
    .sync_out (s_all)
  );

  assign s_sel  = ~s_all[SW-1:2];
  assign s_we_n = s_all[1];
  assign s_oe_n = s_all[0];

  always_comb begin
    sel_count = '0;
    for (int i = 0; i < NUM_BANKS; i++) sel_count = sel_count + SELW'(s_sel[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dual_sel_err <= 1'b0;
    else        dual_sel_err <= (sel_count > SELW'(1));
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_channel #(
      .HOLD_CYCLES  (HOLD_CYCLES),
      .RECOV_CYCLES (RECOV_CYCLES)
    ) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .all_low    (s_sel[b] && !s_we_n && !s_oe_n),
      .exclusive  (sel_count == SELW'(1)),
      .in_rst     (bank_rst[b]),
      .clr_pulse  (stat_clr[b]),
      .init_done  (bank_init[b]),
      .data_valid (data_ok[b])
    );
  end
endmodule

// File: rtl/bank_hold_reset_chk.sv
module bank_hold_reset_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_BANKS-1:0] bank_rst,
  input logic [NUM_BANKS-1:0] stat_clr,
  input logic [NUM_BANKS-1:0] bank_init,
  input logic [NUM_BANKS-1:0] data_ok
);
  // R8: banks reset one at a time
  assert_one_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_rst));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    // R2: the clear strobe only accompanies a reset entry
    assert_clr_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr[b] |-> $rose(bank_rst[b]));
    assert_entry_has_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_rst[b]) |-> stat_clr[b]);
    assert_clr_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      stat_clr[b] |=> !stat_clr[b]);
    // R4: no valid data during reset, and none right at its end
    assert_no_data_in_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bank_rst[b] |-> !data_ok[b]);
    assert_data_not_at_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_rst[b]) |-> !data_ok[b]);
    // R5: initialized at the end of a reset, and sticky afterwards
    assert_init_on_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_rst[b]) |-> bank_init[b]);
    assert_init_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bank_init[b] |=> bank_init[b]);
  end
endmodule

bind bank_hold_reset bank_hold_reset_chk #(.NUM_BANKS(NUM_BANKS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bank_rst  (bank_rst),
  .stat_clr  (stat_clr),
  .bank_init (bank_init),
  .data_ok   (data_ok)
);

// File: tb/test_bank_hold_reset.sv
module test_bank_hold_reset;
  localparam int NB = 2;
  localparam int HOLD = 12;
  localparam int RECOV = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB-1:0] be_n = '1;
  logic we_n = 1'b1, oe_n = 1'b1;
  logic [NB-1:0] bank_rst, stat_clr, bank_init, data_ok;
  logic dual_sel_err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  bank_hold_reset #(.NUM_BANKS(NB), .HOLD_CYCLES(HOLD), .RECOV_CYCLES(RECOV)) i_bank_hold_reset (
    .clk(clk), .rst_n(rst_n), .bank_en_n(be_n), .wr_en_n(we_n), .out_en_n(oe_n),
    .bank_rst(bank_rst), .stat_clr(stat_clr), .bank_init(bank_init),
    .data_ok(data_ok), .dual_sel_err(dual_sel_err)
  );

  // Expected-value model built from the requirements.
  logic [NB+1:0] m1, m2;
  int  e_low [NB];
  int  e_rec [NB];
  bit  e_held[NB], e_recov[NB];
  logic [NB-1:0] e_rst, e_clr, e_init, e_ok;
  logic e_err;

  function automatic int sel_cnt(input logic [NB+1:0] s);
    int n = 0;
    for (int i = 0; i < NB; i++) if (!s[i+2]) n++;
    return n;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= '1; m2 <= '1; e_rst <= '0; e_clr <= '0; e_init <= '0; e_ok <= '1; e_err <= 0;
      for (int b = 0; b < NB; b++) begin
        e_low[b] <= 0; e_rec[b] <= 0; e_held[b] <= 0; e_recov[b] <= 0;
      end
    end else begin
      m1 <= {be_n, we_n, oe_n};
      m2 <= m1;
      e_err <= sel_cnt(m2) > 1;
      for (int b = 0; b < NB; b++) begin
        bit lo, cnt;
        lo  = !m2[b+2] && !m2[1] && !m2[0];
        cnt = lo && sel_cnt(m2) == 1;
        e_clr[b] <= 0;
        if (e_held[b]) begin
          if (!lo) begin
            e_held[b] <= 0; e_rst[b] <= 0; e_init[b] <= 1; e_recov[b] <= 1; e_rec[b] <= 0;
          end
        end else if (cnt && e_low[b] == HOLD) begin
          e_held[b] <= 1; e_rst[b] <= 1; e_clr[b] <= 1; e_ok[b] <= 0; e_low[b] <= 0;
          e_recov[b] <= 0;
        end else begin
          e_low[b] <= cnt ? e_low[b] + 1 : 0;
          if (e_recov[b]) begin
            if (e_rec[b] == RECOV) begin e_ok[b] <= 1; e_recov[b] <= 0; end
            else e_rec[b] <= e_rec[b] + 1;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R1/R3/R8 bank_rst", 32'(bank_rst), 32'(e_rst));
    chk("R2 stat_clr", 32'(stat_clr), 32'(e_clr));
    chk("R4 data_ok", 32'(data_ok), 32'(e_ok));
    chk("R5 bank_init", 32'(bank_init), 32'(e_init));
    chk("R6 dual_sel_err", 32'(dual_sel_err), 32'(e_err));
  endtask

  task automatic idle();
    be_n = '1; we_n = 1; oe_n = 1;
  endtask

  task automatic hold_low(input int b, input int len, output logic seen);
    seen = 0;
    be_n = '1; be_n[b] = 0; we_n = 0; oe_n = 0;
    for (int i = 0; i < len; i++) begin step(); seen |= bank_rst[b]; end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic seen;
    void'($urandom(32'd7351));
    repeat (3) @(negedge clk);
    chk("R1 reset bank_rst", 32'(bank_rst), 0);
    chk("R4 reset data_ok", 32'(data_ok), 32'((1 << NB) - 1));
    chk("R5 reset bank_init", 32'(bank_init), 0);
    rst_n = 1;
    step();

    // R1: exactly HOLD synchronized low cycles must not reset
    hold_low(0, HOLD, seen);
    idle(); repeat (4) begin step(); seen |= bank_rst[0]; end
    chk("R1 exact threshold no reset", 32'(seen), 0);

    // R7: glitch late in a hold restarts the count
    hold_low(0, HOLD - 1, seen);
    idle(); step();
    hold_low(0, HOLD - 1, seen);
    idle(); repeat (4) begin step(); seen |= bank_rst[0]; end
    chk("R7 glitch restarts count", 32'(seen), 0);

    // R1: threshold plus one resets bank 0
    hold_low(0, HOLD + 3, seen);
    chk("R1 reset entered", 32'(bank_rst[0]), 1);
    chk("R8 other bank untouched", 32'(bank_rst[1]), 0);
    // R3/R4/R5: release timing
    oe_n = 1;
    repeat (3) step();
    chk("R3 reset released", 32'(bank_rst[0]), 0);
    chk("R5 init set", 32'(bank_init[0]), 1);
    chk("R4 still recovering", 32'(data_ok[0]), 0);
    repeat (RECOV) step();
    chk("R4 before recovery end", 32'(data_ok[0]), 0);
    step();
    chk("R4 recovery end", 32'(data_ok[0]), 1);

    // R6: both selects low: error, no reset
    be_n = '0; we_n = 0; oe_n = 0;
    seen = 0;
    repeat (HOLD + 6) begin step(); seen |= |bank_rst; end
    chk("R6 error flagged", 32'(dual_sel_err), 1);
    chk("R6 no reset on dual select", 32'(seen), 0);
    idle(); repeat (4) step();

    // Random stimulus
    for (int seg = 0; seg < 600; seg++) begin
      int mode = $urandom_range(0, 5);
      int len;
      case (mode)
        0: begin
          len = $urandom_range(1, 8);
          repeat (len) begin
            be_n = NB'($urandom); we_n = 1'($urandom); oe_n = 1'($urandom); step();
          end
        end
        1, 2: begin
          hold_low($urandom_range(0, NB - 1), $urandom_range(HOLD - 2, HOLD + 8), seen);
        end
        3: begin
          len = $urandom_range(1, RECOV + 4);
          idle(); repeat (len) step();
        end
        4: begin
          be_n = '0; we_n = 0; oe_n = 0;
          repeat ($urandom_range(2, 6)) step();
        end
        default: begin
          int b = $urandom_range(0, NB - 1);
          hold_low(b, $urandom_range(3, HOLD), seen);
          we_n = 1; step();
          hold_low(b, $urandom_range(3, HOLD), seen);
        end
      endcase
    end
    idle(); repeat (RECOV + 6) step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule